// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Generator

This block picks one winner among sixteen interrupt priority slots and presents the 16-bit address of that slot's vector word to the instruction fetch logic. Slot numbers are priorities: slot 15 is the highest and slot 0 the lowest. The vector word address is `VEC_BASE + 2*slot`, so the table runs from 0FFE0h for slot 0 up to 0FFFEh for slot 15. Several peripheral flags may be ORed onto one slot request line outside this block.

Slot 15 is the reset slot and no enable can mask it. Slot 14 is the non-maskable slot. Its own enable bit gates it, but the global enable has no effect on it. Slots 0 to 13 need both the global enable and their own enable. The block also watches every fetch address. A fetch from the peripheral register space or from one of the configured unused windows raises a one-cycle reset request. The same fetch makes the reset slot pending until the reset vector is acknowledged.

Once a winner is captured, `irq_o` stays high and the vector stays fixed until the CPU acknowledges it. The only exception is a reset-slot request, which replaces a held lower-priority vector. On acknowledge the block emits a one-hot strobe naming the served slot, so the owning peripheral can clear its flag.

Top module: `irq_vector_gen`

## Requirements
- R1: After synchronous reset, `irq_o`, `vec_addr_o`, `ack_slot_o` and `reset_req_o` are all zero.
- R2: While `irq_o` is high, `vec_addr_o` equals 0FFE0h + 2*slot for the captured slot. For example, slot 0 gives 0FFE0h, slot 6 gives 0FFECh, slot 12 gives 0FFF8h and slot 15 gives 0FFFEh. A pending slot is captured at the first clock edge after it becomes eligible while `irq_o` is low.
- R3: When several eligible slots are pending at the same edge, the highest-numbered slot is captured.
- R4: Slots 0 to 13 are eligible only when `gie_i` is 1 and their bit in `slot_en_i` is 1. Otherwise they are ignored and `irq_o` stays low.
- R5: Slot 14 is eligible when its bit in `slot_en_i` is 1, whatever the value of `gie_i`. It is ignored when that bit is 0.
- R6: Slot 15 is eligible whenever it is requested, whatever the values of `gie_i` and `slot_en_i`.
- R7: While `irq_o` is high and `ack_i` is low, `irq_o` and `vec_addr_o` hold their values. This holds when a higher slot in the range 0 to 14 arrives and when the held request is withdrawn. Only slot 15 may replace the held vector.
- R8: At a clock edge with `ack_i` and `irq_o` both high, `irq_o` falls and `ack_slot_o` shows bit `slot` for exactly one cycle. At the next edge the block arbitrates again. When `irq_o` is low, `ack_i` is ignored.
- R9: A cycle with `fetch_valid_i` high raises `reset_req_o` for the following cycle if `fetch_addr_i` lies in any of these ranges: 0000h–01FFh, 0300h–0BFFh or 1100h–7FFFh (all bounds inclusive, by default). Addresses 0200h, 0C00h, 10FFh and 8000h do not raise it.
- R10: An illegal fetch makes slot 15 pending from the same edge that raises `reset_req_o`, even if `req_i[15]` is low. That edge replaces any held lower vector with 0FFFEh. Slot 15 stays pending until it is acknowledged.
- R11: When `fetch_valid_i` is low, `fetch_addr_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | Request line per priority slot |
| slot_en_i | input | 16 | Individual enable per slot (bit 15 unused) |
| gie_i | input | 1 | Global enable for slots 0 to 13 |
| fetch_valid_i | input | 1 | Qualifies `fetch_addr_i` |
| fetch_addr_i | input | 16 | Address of the current instruction fetch |
| ack_i | input | 1 | CPU accepts the presented vector |
| irq_o | output | 1 | A vector is being presented |
| vec_addr_o | output | 16 | Vector word address of the captured slot |
| ack_slot_o | output | 16 | One-hot, one-cycle strobe of the acknowledged slot |
| reset_req_o | output | 1 | One-cycle reset request after an illegal fetch |

## Verification
A wrong captured slot shows up on `vec_addr_o` at the first edge after the request. One cycle later, on acknowledge, `ack_slot_o` names the slot that was captured. A corrupted hold or a pending flag that never clears leaves `irq_o` high, or raises it again, in the cycle after an acknowledge. A fault in the window compare shows at a single edge: `reset_req_o` rises or stays low on the exact boundary addresses. Tests of the mask decode toggle one enable at a time and watch whether `irq_o` ever rises.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_HOLD = 1'b1
  } hold_st_t;

  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (addr >= lo) && (addr <= hi);
  endfunction

endpackage

// File: rtl/irqv_mask.sv
module irqv_mask #(
  parameter int N        = 16,
  parameter int RST_SLOT = 15,
  parameter int NMI_SLOT = 14
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  input  logic         gie_i,
  output logic [N-1:0] elig_o
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    if (i == RST_SLOT) begin : g_rst
      assign elig_o[i] = pend_i[i];
    end else if (i == NMI_SLOT) begin : g_nmi
      assign elig_o[i] = pend_i[i] & en_i[i];
    end else begin : g_mask
      assign elig_o[i] = pend_i[i] & en_i[i] & gie_i;
    end
  end

endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int N      = 16,
  localparam int SLOT_W = $clog2(N)
) (
  input  logic [N-1:0]      elig_i,
  output logic              any_o,
  output logic [SLOT_W-1:0] win_o
);

  always_comb begin
    win_o = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i]) win_o = SLOT_W'(i);
    end
  end

  assign any_o = |elig_i;

endmodule

// File: rtl/irqv_range_chk.sv
module irqv_range_chk #(
  parameter int                     ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]      REG_TOP  = 16'h01FF,
  parameter int                     NUM_GAPS = 2,
  parameter logic [NUM_GAPS*ADDR_W-1:0] GAP_LO = {16'h1100, 16'h0300},
  parameter logic [NUM_GAPS*ADDR_W-1:0] GAP_HI = {16'h7FFF, 16'h0BFF}
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bad_o
);
  import irqv_pkg::*;

  logic [NUM_GAPS:0] hit;

  assign hit[0] = addr_i <= REG_TOP;

  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
    assign hit[g+1] = in_window(32'(addr_i),
                                32'(GAP_LO[g*ADDR_W +: ADDR_W]),
                                32'(GAP_HI[g*ADDR_W +: ADDR_W]));
  end

  assign bad_o = valid_i & (|hit);

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int                          NUM_SLOTS = 16,
  parameter int                          ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]           VEC_BASE  = 16'hFFE0,
  parameter int                          RST_SLOT  = 15,
  parameter int                          NMI_SLOT  = 14,
  parameter logic [ADDR_W-1:0]           REG_TOP   = 16'h01FF,
  parameter int                          NUM_GAPS  = 2,
  parameter logic [NUM_GAPS*ADDR_W-1:0]  GAP_LO    = {16'h1100, 16'h0300},
  parameter logic [NUM_GAPS*ADDR_W-1:0]  GAP_HI    = {16'h7FFF, 16'h0BFF}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] req_i,
  input  logic [NUM_SLOTS-1:0] slot_en_i,
  input  logic                 gie_i,
  input  logic                 fetch_valid_i,
  input  logic [ADDR_W-1:0]    fetch_addr_i,
  input  logic                 ack_i,
  output logic                 irq_o,
  output logic [ADDR_W-1:0]    vec_addr_o,
  output logic [NUM_SLOTS-1:0] ack_slot_o,
  output logic                 reset_req_o
);
  import irqv_pkg::*;

  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam logic [SLOT_W-1:0] RST_IDX = SLOT_W'(RST_SLOT);

  hold_st_t            st_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [ADDR_W-1:0]   vec_q;
  logic [NUM_SLOTS-1:0] ack_q;
  logic                rr_q;
  logic                oob_pend_q;

  logic                 oob_hit;
  logic [NUM_SLOTS-1:0] pend;
  logic [NUM_SLOTS-1:0] elig;
  logic                 any_elig;
  logic [SLOT_W-1:0]    win;
  logic                 take_ack;
  logic                 preempt;

  irqv_range_chk #(
    .ADDR_W  (ADDR_W),
    .REG_TOP (REG_TOP),
    .NUM_GAPS(NUM_GAPS),
    .GAP_LO  (GAP_LO),
    .GAP_HI  (GAP_HI)
  ) u_range (
    .valid_i(fetch_valid_i),
    .addr_i (fetch_addr_i),
    .bad_o  (oob_hit)
  );

  always_comb begin
    pend           = req_i;
    pend[RST_SLOT] = req_i[RST_SLOT] | oob_pend_q | oob_hit;
  end

  irqv_mask #(
    .N       (NUM_SLOTS),
    .RST_SLOT(RST_SLOT),
    .NMI_SLOT(NMI_SLOT)
  ) u_mask (
    .pend_i(pend),
    .en_i  (slot_en_i),
    .gie_i (gie_i),
    .elig_o(elig)
  );

  irqv_prio_enc #(
    .N(NUM_SLOTS)
  ) u_enc (
    .elig_i(elig),
    .any_o (any_elig),
    .win_o (win)
  );

  function automatic logic [ADDR_W-1:0] vec_of(input logic [SLOT_W-1:0] s);
    return VEC_BASE + ADDR_W'({s, 1'b0});
  endfunction

  assign take_ack = (st_q == HS_HOLD) && ack_i;
  assign preempt  = (st_q == HS_HOLD) && !ack_i && elig[RST_SLOT] && (slot_q != RST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= HS_IDLE;
      slot_q     <= '0;
      vec_q      <= '0;
      ack_q      <= '0;
      rr_q       <= 1'b0;
      oob_pend_q <= 1'b0;
    end else begin
      rr_q       <= oob_hit;
      ack_q      <= '0;
      oob_pend_q <= oob_hit | (oob_pend_q & ~(take_ack && slot_q == RST_IDX));
      if (take_ack) begin
        st_q          <= HS_IDLE;
        ack_q[slot_q] <= 1'b1;
      end else if (preempt) begin
        slot_q <= RST_IDX;
        vec_q  <= vec_of(RST_IDX);
      end else if (st_q == HS_IDLE && any_elig) begin
        st_q   <= HS_HOLD;
        slot_q <= win;
        vec_q  <= vec_of(win);
      end
    end
  end

  assign irq_o       = (st_q == HS_HOLD);
  assign vec_addr_o  = vec_q;
  assign ack_slot_o  = ack_q;
  assign reset_req_o = rr_q;

endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int                NUM_SLOTS = 16,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 16'hFFE0,
  parameter int                RST_SLOT  = 15
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ack_i,
  input logic                 fetch_valid_i,
  input logic                 irq_o,
  input logic [ADDR_W-1:0]    vec_addr_o,
  input logic [NUM_SLOTS-1:0] ack_slot_o,
  input logic                 reset_req_o
);

  localparam logic [ADDR_W-1:0] TOP_VEC = VEC_BASE + ADDR_W'(2 * RST_SLOT);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && ack_slot_o == '0 && !reset_req_o));

  // R2
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (vec_addr_o >= VEC_BASE && vec_addr_o <= TOP_VEC && !vec_addr_o[0]));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i) |=> irq_o);

  // R7
  top_vec_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i && vec_addr_o == TOP_VEC) |=> $stable(vec_addr_o));

  // R8
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_slot_o));

  // R8
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i) |=> ($countones(ack_slot_o) == 1 && !irq_o));

  // R8
  ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_o || !ack_i) |=> (ack_slot_o == '0));

  // R11
  rr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid_i |=> !reset_req_o);

  // R10
  rr_vec_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req_o |-> (irq_o && vec_addr_o == TOP_VEC));

endmodule

bind irq_vector_gen irqv_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .ADDR_W   (ADDR_W),
  .VEC_BASE (VEC_BASE),
  .RST_SLOT (RST_SLOT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ack_i        (ack_i),
  .fetch_valid_i(fetch_valid_i),
  .irq_o        (irq_o),
  .vec_addr_o   (vec_addr_o),
  .ack_slot_o   (ack_slot_o),
  .reset_req_o  (reset_req_o)
);

// File: tb/irq_vector_gen_tb.sv
module irq_vector_gen_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] req_i;
  logic [15:0] slot_en_i;
  logic        gie_i;
  logic        fetch_valid_i;
  logic [15:0] fetch_addr_i;
  logic        ack_i;
  logic        irq_o;
  logic [15:0] vec_addr_o;
  logic [15:0] ack_slot_o;
  logic        reset_req_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  irq_vector_gen u_dut (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_i),
    .slot_en_i    (slot_en_i),
    .gie_i        (gie_i),
    .fetch_valid_i(fetch_valid_i),
    .fetch_addr_i (fetch_addr_i),
    .ack_i        (ack_i),
    .irq_o        (irq_o),
    .vec_addr_o   (vec_addr_o),
    .ack_slot_o   (ack_slot_o),
    .reset_req_o  (reset_req_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    req_i = '0; slot_en_i = '1; gie_i = 1'b1;
    fetch_valid_i = 1'b0; fetch_addr_i = 16'hC000; ack_i = 1'b0;
  endtask

  // acknowledge the presented vector and check the strobe
  task automatic do_ack(input string tag, input int slot);
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    check({tag, " ack strobe"}, 32'(ack_slot_o), 32'(16'h1 << slot));
    check({tag, " irq low after ack"}, 32'(irq_o), 0);
  endtask

  task automatic t_reset();
    idle_inputs();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    check("R1 irq", 32'(irq_o), 0);
    check("R1 vec", 32'(vec_addr_o), 0);
    check("R1 ack", 32'(ack_slot_o), 0);
    check("R1 rr", 32'(reset_req_o), 0);
  endtask

  task automatic t_single();
    req_i = 16'h0040;
    step();
    check("R2 irq slot6", 32'(irq_o), 1);
    check("R2 vec slot6", 32'(vec_addr_o), 32'hFFEC);
    req_i = '0;
    do_ack("R8 slot6", 6);
    step();
    check("R8 no re-capture", 32'(irq_o), 0);
    check("R8 strobe one cycle", 32'(ack_slot_o), 0);
    req_i = 16'h0001;
    step();
    check("R2 vec slot0", 32'(vec_addr_o), 32'hFFE0);
    req_i = '0;
    do_ack("R8 slot0", 0);
    step();
  endtask

  task automatic t_prio();
    req_i = 16'h1208;
    step();
    check("R3 vec highest", 32'(vec_addr_o), 32'hFFF8);
    req_i = '0;
    do_ack("R3 slot12", 12);
    step();
  endtask

  task automatic t_gie();
    gie_i = 1'b0; req_i = 16'h2020;
    step(); step();
    check("R4 gie off", 32'(irq_o), 0);
    gie_i = 1'b1; slot_en_i = 16'hFFDF; req_i = 16'h0020;
    step(); step();
    check("R4 own enable off", 32'(irq_o), 0);
    slot_en_i = '1; req_i = '0;
    step();
  endtask

  task automatic t_nmi();
    gie_i = 1'b0; req_i = 16'h4000;
    step();
    check("R5 nmi ignores gie", 32'(vec_addr_o), 32'hFFFC);
    req_i = '0;
    do_ack("R5 slot14", 14);
    slot_en_i = 16'hBFFF; req_i = 16'h4000;
    step(); step();
    check("R5 nmi own enable", 32'(irq_o), 0);
    req_i = '0; slot_en_i = '1; gie_i = 1'b1;
    step();
  endtask

  task automatic t_rst_slot();
    gie_i = 1'b0; slot_en_i = '0; req_i = 16'h8000;
    step();
    check("R6 reset slot unmasked", 32'(vec_addr_o), 32'hFFFE);
    req_i = '0;
    do_ack("R6 slot15", 15);
    gie_i = 1'b1; slot_en_i = '1;
    step();
  endtask

  task automatic t_hold();
    req_i = 16'h0010;
    step();
    check("R7 captured slot4", 32'(vec_addr_o), 32'hFFE8);
    req_i = 16'h4010;
    step(); step();
    check("R7 hold vs higher", 32'(vec_addr_o), 32'hFFE8);
    req_i = 16'h4000;
    step();
    check("R7 hold after withdraw", 32'(vec_addr_o), 32'hFFE8);
    check("R7 irq held", 32'(irq_o), 1);
    do_ack("R7 slot4", 4);
    step();
    check("R8 rearbitrate", 32'(vec_addr_o), 32'hFFFC);
    req_i = '0;
    do_ack("R8 slot14", 14);
    step();
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    check("R8 idle ack ignored", 32'(ack_slot_o), 0);
  endtask

  task automatic probe(input logic [15:0] addr, input bit expect_bad);
    fetch_valid_i = 1'b1; fetch_addr_i = addr;
    step();
    fetch_valid_i = 1'b0; fetch_addr_i = 16'hC000;
    check($sformatf("R9 rr at %h", addr), 32'(reset_req_o), 32'(expect_bad));
    if (expect_bad) begin
      check($sformatf("R10 vec at %h", addr), 32'(vec_addr_o), 32'hFFFE);
      step();
      check("R9 rr one cycle", 32'(reset_req_o), 0);
      do_ack("R10 oob", 15);
      step();
      check("R10 cleared by ack", 32'(irq_o), 0);
    end else begin
      check($sformatf("R9 no irq at %h", addr), 32'(irq_o), 0);
    end
  endtask

  task automatic t_range();
    probe(16'h0100, 1'b1);
    probe(16'h01FF, 1'b1);
    probe(16'h0200, 1'b0);
    probe(16'h0300, 1'b1);
    probe(16'h0BFF, 1'b1);
    probe(16'h0C00, 1'b0);
    probe(16'h10FF, 1'b0);
    probe(16'h1100, 1'b1);
    probe(16'h7FFF, 1'b1);
    probe(16'h8000, 1'b0);
    fetch_valid_i = 1'b0; fetch_addr_i = 16'h0000;
    step(); step();
    check("R11 invalid fetch rr", 32'(reset_req_o), 0);
    check("R11 invalid fetch irq", 32'(irq_o), 0);
    fetch_addr_i = 16'hC000;
  endtask

  task automatic t_preempt();
    req_i = 16'h0008;
    step();
    check("R10 held slot3", 32'(vec_addr_o), 32'hFFE6);
    fetch_valid_i = 1'b1; fetch_addr_i = 16'h0400;
    step();
    fetch_valid_i = 1'b0; fetch_addr_i = 16'hC000;
    check("R10 preempt vec", 32'(vec_addr_o), 32'hFFFE);
    check("R10 preempt rr", 32'(reset_req_o), 1);
    step();
    check("R10 pending holds", 32'(vec_addr_o), 32'hFFFE);
    do_ack("R10 preempt", 15);
    step();
    check("R10 slot3 returns", 32'(vec_addr_o), 32'hFFE6);
    req_i = '0;
    do_ack("R10 slot3", 3);
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_prio();
    t_gie();
    t_nmi();
    t_rst_slot();
    t_hold();
    t_range();
    t_preempt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule